// File: doc/BRIEF.md
# Two-Branch Glitch-Free Clock Divider Selector

This block produces one divided clock enable from a bank of source clock enables. Each source is modelled as a strobe that is high for one cycle of the fabric clock whenever that source would have a rising edge. Two identical divider branches sit side by side in one 32-bit control word. Each branch has its own enable, source select and divide value. A single select bit decides which branch drives the output.

To change frequency, software configures the branch that is idle and then flips the select bit. The block moves the output over in a break-before-make sequence. The old branch's gate request passes through a two-flop synchroniser. The old gate then closes only when that branch's divide counter is at the start of a period. After that, the new branch's request passes through its own two-flop synchroniser, and the new gate opens at that branch's period start. A read-only busy flag covers the whole sequence. The select bit cannot be changed while the flag is set.

Top module: `pingpong_clkdiv`

## Requirements
- R1: After reset the control word reads 0, busy is low, and the output enable never pulses while the registers stay unwritten.
- R2: The control word reads back as written in these bits: branch A enable at bit 13, source at [12:10] and divide at [9:0]; branch B enable at bit 29, source at [28:26] and divide at [25:16]; the select bit at 15. Busy reads at bit 31. Bits 14 and 30 read 0.
- R3: An enabled branch with divide value N issues one output pulse per N+1 pulses of its chosen source. In steady state the spacing between output pulses is exactly (N+1) times the source period.
- R4: Source code k (0 to 7) selects source strobe k. The eight codes stand for: oscillator, fixed PLL /2.5, fixed PLL /3, RTC PLL, audio PLL, fixed PLL /4, general-purpose PLL 1, and the RTC clock.
- R5: While the selected branch has its enable bit clear, the output never pulses.
- R6: Select bit 0 routes branch A and select bit 1 routes branch B. After a handover completes, the output spacing matches the newly selected branch. The two branch gates are never open at the same time.
- R7: A write that changes the select bit while busy is low makes busy read 1 in the next cycle. Busy stays high until the new branch's gate is open, and then returns to 0.
- R8: While busy is high, the select bit of a write is ignored, but that write's branch fields still take effect.
- R9: Rewriting the fields of the idle branch leaves the output spacing of the active branch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcEn | input | 8 | Source clock enables, one strobe per source edge |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word write data |
| rdData | output | 32 | Control word read data, with busy at bit 31 |
| outEn | output | 1 | Divided output clock enable (registered) |

## Verification
The bench drives source k with a strobe every k+1 cycles. It sweeps every source code against several divide values, and the handovers between sweep steps alternate between the two branches. Each steady-state output gap must equal (k+1)(N+1). A design with swapped field positions, an off-by-one divider, or a wrong source index shows a different gap. A design that failed to complete a handover would keep the old spacing or leave busy stuck high. The bench also checks the following cases:
- A select write landing during busy: a design that accepts it would end on the wrong branch.
- Selecting a disabled branch: a leaky gate would emit pulses.
- Rewriting the idle branch's fields: a design that disturbs the active counter would shift its spacing.

// File: rtl/ppcd_pkg.sv
package ppcd_pkg;
  parameter int DIV_W = 10;
  parameter int SEL_W = 3;
  localparam int N_SRC = 1 << SEL_W;
  localparam int CFG_W = 1 + SEL_W + DIV_W;

  // Branch configuration, laid out exactly as in the control word field
  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] src;
    logic [DIV_W-1:0] div;
  } branchCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] gateWant;   // desired gate state per branch (pre-synchroniser)
    logic [1:0] cntClr;     // restart divider of a branch whose fields changed
  } ppStrobe_t;
endpackage

// File: rtl/ppcd_ctrl.sv
module ppcd_ctrl
  import ppcd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  input  logic [1:0]          gateOpen,
  output branchCfg_t [1:0]    cfg,
  output ppStrobe_t           strobes,
  output logic [31:0]         rdData
);
  typedef enum logic [1:0] {HS_IDLE, HS_DROP, HS_LIFT} hsState_t;

  hsState_t   state;
  logic       selBit;
  logic [1:0] want;
  branchCfg_t [1:0] wrCfg;
  logic       busy;
  logic       toggle;
  logic       oldIdx;
  logic       unusedWr;

  assign wrCfg[0] = wrData[CFG_W-1:0];
  assign wrCfg[1] = wrData[16+CFG_W-1:16];
  assign busy     = (state != HS_IDLE);
  assign toggle   = wrEn && !busy && (wrData[15] != selBit);
  assign oldIdx   = !selBit;
  assign unusedWr = ^{wrData[31:30], wrData[14]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      selBit <= 1'b0;
      want   <= 2'b01;
      state  <= HS_IDLE;
    end else begin
      if (wrEn) cfg <= wrCfg;
      unique case (state)
        HS_IDLE: if (toggle) begin
          selBit        <= wrData[15];
          want[selBit]  <= 1'b0;
          state         <= HS_DROP;
        end
        HS_DROP: if (!gateOpen[oldIdx]) begin
          want[selBit]  <= 1'b1;
          state         <= HS_LIFT;
        end
        HS_LIFT: if (gateOpen[selBit]) state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.gateWant = want;
    for (int i = 0; i < 2; i++)
      strobes.cntClr[i] = wrEn && (wrCfg[i] != cfg[i]);
  end

  assign rdData = {busy, 1'b0, cfg[1], selBit, 1'b0, cfg[0]};
endmodule

// File: rtl/ppcd_dpath.sv
module ppcd_dpath
  import ppcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_SRC-1:0]   srcEn,
  input  branchCfg_t [1:0]   cfg,
  input  ppStrobe_t          strobes,
  output logic [1:0]         gateOpen,
  output logic               outEn
);
  logic [1:0] tick;

  for (genvar b = 0; b < 2; b++) begin : g_branch
    localparam logic RST_OPEN = (b == 0);
    logic [DIV_W-1:0] cnt;
    logic             syncA, syncB;
    logic             pulse, wrap;

    assign pulse   = cfg[b].en && srcEn[cfg[b].src];
    assign wrap    = (cnt == cfg[b].div);
    assign tick[b] = pulse && wrap;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt         <= '0;
        syncA       <= RST_OPEN;
        syncB       <= RST_OPEN;
        gateOpen[b] <= RST_OPEN;
      end else begin
        syncA <= strobes.gateWant[b];
        syncB <= syncA;
        if (strobes.cntClr[b] || !cfg[b].en) cnt <= '0;
        else if (pulse) cnt <= wrap ? '0 : cnt + 1'b1;
        // gate moves only at the start of a divider period
        if (cnt == '0) gateOpen[b] <= syncB;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outEn <= 1'b0;
    else       outEn <= |(gateOpen & tick);
  end
endmodule

// File: rtl/pingpong_clkdiv.sv
module pingpong_clkdiv
  import ppcd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] srcEn,
  input  logic             wrEn,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             outEn
);
  branchCfg_t [1:0] cfg;
  ppStrobe_t        strobes;
  logic [1:0]       gateOpen;

  ppcd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .gateOpen(gateOpen), .cfg(cfg), .strobes(strobes), .rdData(rdData)
  );

  ppcd_dpath i_dpath (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .cfg(cfg),
    .strobes(strobes), .gateOpen(gateOpen), .outEn(outEn)
  );
endmodule

// File: rtl/ppcd_chk.sv
module ppcd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrSel,
  input logic       busy,
  input logic       curSel,
  input logic       enA,
  input logic       enB,
  input logic [1:0] gateOpen,
  input logic       outEn
);
  logic activeEn;
  assign activeEn = curSel ? enB : enA;

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && (wrSel != curSel)) |=> busy);

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curSel));

  // R6
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateOpen));

  // R5
  no_pulse_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !activeEn && !$past(activeEn)) |-> !outEn);

  // R7
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> gateOpen[curSel]);
endmodule

bind pingpong_clkdiv ppcd_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrData[15]),
  .busy(rdData[31]), .curSel(rdData[15]), .enA(rdData[13]), .enB(rdData[29]),
  .gateOpen(gateOpen), .outEn(outEn)
);

// File: tb/test_pingpong_clkdiv.sv
`timescale 1ns/1ps
module test_pingpong_clkdiv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  srcEn = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        outEn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] cur = '0;

  always #4 clk = ~clk;

  pingpong_clkdiv i_pingpong_clkdiv (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .outEn(outEn)
  );

  // source k strobes every k+1 cycles
  initial forever begin
    @(negedge clk);
    cyc++;
    for (int k = 0; k < 8; k++) srcEn[k] = ((cyc % (k + 1)) == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input logic en, input int src, input int div);
    return {en, src[2:0], div[9:0]};
  endfunction

  task automatic wrReg(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (rdData[31] && n < 3000) begin @(negedge clk); n++; end
    check("R7 busy clears", {31'd0, rdData[31]}, 32'd0);
  endtask

  task automatic getGap(output int gap);
    int n = 0;
    while (!outEn && n < 4000) begin @(negedge clk); n++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!outEn && gap < 4000);
  endtask

  task automatic period(output int gap);
    int g;
    getGap(g);
    getGap(gap);
  endtask

  // program idle branch, flip select, wait for handover
  task automatic switchTo(input logic [13:0] f);
    logic tgt;
    tgt = !cur[15];
    if (tgt) cur[29:16] = f; else cur[13:0] = f;
    wrReg(cur);
    cur[15] = tgt;
    wrReg(cur);
    check("R7 busy after toggle", {31'd0, rdData[31]}, 32'd1);
    waitIdle();
    check("R6 select readback", {31'd0, rdData[15]}, {31'd0, tgt});
  endtask

  initial begin
    int gap;
    int cnt;
    int divs[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset word", rdData, 32'd0);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (outEn) cnt++; end
    check("R1 no pulses", cnt, 0);

    // R2: all bits except select written as 1
    wrReg(32'hFFFF_7FFF);
    cur = 32'h3FFF_3FFF;
    check("R2 readback", rdData, 32'h3FFF_3FFF);
    wrReg(32'h0);
    cur = 32'h0;
    check("R2 clear", rdData, 32'h0);

    // R5: selected branch disabled
    switchTo(mk(1'b0, 0, 0));
    cnt = 0;
    repeat (200) begin @(negedge clk); if (outEn) cnt++; end
    check("R5 disabled branch silent", cnt, 0);

    // R3 R4 R6: sweep every source against several dividers, ping-pong
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 4; d++) begin
        switchTo(mk(1'b1, s, divs[d]));
        period(gap);
        check($sformatf("R3 R4 src %0d div %0d", s, divs[d]), gap, (s + 1) * (divs[d] + 1));
      end
    end

    // R9: rewrite idle branch while active keeps running
    switchTo(mk(1'b1, 2, 3));
    if (cur[15]) cur[13:0] = mk(1'b1, 6, 1); else cur[29:16] = mk(1'b1, 6, 1);
    wrReg(cur);
    period(gap);
    check("R9 idle rewrite no effect", gap, 12);

    // R8: select write during busy is ignored, fields still land
    begin
      logic tgt;
      logic [31:0] second;
      tgt = !cur[15];
      if (tgt) cur[29:16] = mk(1'b1, 1, 2); else cur[13:0] = mk(1'b1, 1, 2);
      wrReg(cur);
      cur[15] = tgt;
      wrReg(cur);
      second = cur;
      second[15] = !tgt;
      if (tgt) second[13:0] = mk(1'b1, 4, 9); else second[29:16] = mk(1'b1, 4, 9);
      wrReg(second);
      cur = second;
      cur[15] = tgt;
      waitIdle();
      check("R8 select held", {31'd0, rdData[15]}, {31'd0, tgt});
      check("R8 fields taken", rdData, cur);
      period(gap);
      check("R8 output follows target", gap, 6);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule